// File: doc/BRIEF.md
# Four-Lane 16-bit Packed Multiplier

This unit takes two 64-bit operands. Each operand carries four independent 16-bit lanes, and the unit multiplies the matching lanes of the two operands in parallel. Each lane forms a 32-bit intermediate product. A 2-bit opcode decides what reaches the 64-bit result:

- the low halves of the four products;
- the high halves, with the operands taken as signed;
- the high halves, with the operands taken as unsigned;
- a pairwise multiply-add that folds the four signed products into two 32-bit sums.

Software that needs a full 32-bit product issues the low-half operation and then one of the high-half operations on the same operands, and combines the two results.

The unit is a two-stage pipeline with no back-pressure. It accepts a new operation on every cycle in which `in_valid` is high. The matching result appears with `out_valid` exactly two cycles later. Between valid results the output register keeps its last value.

Top module: `lmu_top`

## Requirements
- R1: Lane k of each operand and of the result occupies bits 16k+15 down to 16k (lane 0 is bits 15:0). The opcode `in_op` selects the operation: 00 = low half, 01 = signed high half, 10 = unsigned high half, 11 = multiply-add.
- R2: With opcode 00, each result lane is bits 15:0 of its 32-bit lane product. This value is the same whether the operands are read as signed or unsigned, so there is only one low-half operation.
- R3: With opcode 01, each result lane is bits 31:16 of the product of the two lanes read as two's-complement numbers.
- R4: With opcode 10, each result lane is bits 31:16 of the product of the two lanes read as unsigned numbers.
- R5: For the same operands, placing a high-half result lane above the low-half result lane gives the full 32-bit product. The signed high half gives the signed product and the unsigned high half gives the unsigned product.
- R6: With opcode 11, result bits 31:0 hold the sum of the signed products of lanes 0 and 1, and bits 63:32 hold the sum of the signed products of lanes 2 and 3. Each sum wraps modulo 2^32, so four lanes of -32768 give 0x80000000.
- R7: `out_valid` rises exactly two clock cycles after the cycle in which `in_valid` was sampled high, and is low in every other cycle. Operations may be issued on back-to-back cycles.
- R8: In any cycle without a valid result, `out_data` keeps the value of the most recent result.
- R9: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is all zeros until the first result arrives. The reset asserts asynchronously and is released on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 2 | Operation select |
| in_a | input | 64 | First packed operand, four 16-bit lanes |
| in_b | input | 64 | Second packed operand, four 16-bit lanes |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_data | output | 64 | Packed result |

## Verification
Some behaviour is checked by assertions on every cycle:

- the valid strobe moves one stage per cycle;
- the output register holds its value when no result is due;
- each lane's stored product agrees in its low 16 bits with a plain unsigned multiply, whatever the signedness.

The arithmetic of each opcode can only be shown by the bench's scenarios:

- signed and unsigned high halves at the extreme operand values;
- carries and wrap-around in the pairwise sums;
- rebuilding full products from a low/high pair.

The bench also checks lane placement, using rotated operand patterns in which every lane differs.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  typedef enum logic [1:0] {
    LMU_MUL_LO   = 2'b00,
    LMU_MUL_HI_S = 2'b01,
    LMU_MUL_HI_U = 2'b10,
    LMU_MADD     = 2'b11
  } lmu_op_e;
endpackage

// File: rtl/lmu_rst_sync.sv
module lmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lmu_lane_mult.sv
module lmu_lane_mult #(
  parameter int LANE_W = 16,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sgn_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_x;
  logic signed [PROD_W-1:0] b_x;
  logic        [PROD_W-1:0] prod_d;
  logic        [PROD_W-1:0] prod_q;
  logic        [LANE_W-1:0] chk_lo;

  // Extending by the sign bit or by zero gives both signedness modes from one array.
  always_comb begin
    a_x = {{LANE_W{sgn_i & a_i[LANE_W-1]}}, a_i};
    b_x = {{LANE_W{sgn_i & b_i[LANE_W-1]}}, b_i};
  end

  always_comb begin
    prod_d = prod_q;
    if (en_i) prod_d = a_x * b_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod_o = prod_q;

  // A separate narrow unsigned product, used only by the check below.
  assign chk_lo = a_i * b_i;

  AST_LOW_SIGN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (prod_q[LANE_W-1:0] == $past(chk_lo))); // R2
endmodule

// File: rtl/lmu_result_fmt.sv
module lmu_result_fmt
  import lmu_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PAIRS  = LANES / 2
) (
  input  logic [1:0]              op_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  output logic [DATA_W-1:0]       res_o
);
  logic [DATA_W-1:0]       lo_v;
  logic [DATA_W-1:0]       hi_v;
  logic [PAIRS*PROD_W-1:0] madd_v;

  for (genvar l = 0; l < LANES; l++) begin : g_half
    assign lo_v[l*LANE_W +: LANE_W] = prod_i[l*PROD_W +: LANE_W];
    assign hi_v[l*LANE_W +: LANE_W] = prod_i[l*PROD_W + LANE_W +: LANE_W];
  end

  // Each sum wraps at the product width.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign madd_v[p*PROD_W +: PROD_W] =
      prod_i[(2*p)*PROD_W +: PROD_W] + prod_i[(2*p+1)*PROD_W +: PROD_W];
  end

  always_comb begin
    case (lmu_op_e'(op_i))
      LMU_MUL_LO:   res_o = lo_v;
      LMU_MUL_HI_S: res_o = hi_v;
      LMU_MUL_HI_U: res_o = hi_v;
      LMU_MADD:     res_o = madd_v;
      default:      res_o = lo_v;
    endcase
  end
endmodule

// File: rtl/lmu_top.sv
module lmu_top
  import lmu_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int PROD_W = 2 * LANE_W,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic                      rst_s_n;
  logic                      mul_signed;
  logic [LANES*PROD_W-1:0]   prod_flat;
  logic [DATA_W-1:0]         fmt_res;

  logic                      s1_valid_d, s1_valid_q;
  logic [1:0]                s1_op_d, s1_op_q;
  logic                      out_valid_d, out_valid_q;
  logic [DATA_W-1:0]         out_data_d, out_data_q;

  lmu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // Only the unsigned high half reads its operands as unsigned.
  assign mul_signed = (lmu_op_e'(in_op) != LMU_MUL_HI_U);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lmu_lane_mult #(.LANE_W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .en_i   (in_valid),
      .sgn_i  (mul_signed),
      .a_i    (in_a[l*LANE_W +: LANE_W]),
      .b_i    (in_b[l*LANE_W +: LANE_W]),
      .prod_o (prod_flat[l*PROD_W +: PROD_W])
    );
  end

  lmu_result_fmt #(.LANE_W(LANE_W), .LANES(LANES)) u_fmt (
    .op_i   (s1_op_q),
    .prod_i (prod_flat),
    .res_o  (fmt_res)
  );

  always_comb begin
    s1_valid_d  = in_valid;
    s1_op_d     = in_valid ? in_op : s1_op_q;
    out_valid_d = s1_valid_q;
    out_data_d  = s1_valid_q ? fmt_res : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s1_valid_q  <= 1'b0;
      s1_op_q     <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      s1_valid_q  <= s1_valid_d;
      s1_op_q     <= s1_op_d;
      out_valid_q <= out_valid_d;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> s1_valid_q); // R7
  AST_RESULT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    s1_valid_q |=> out_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_s_n)
    !s1_valid_q |=> !out_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !s1_valid_q |=> $stable(out_data)); // R8
endmodule

// File: tb/lmu_top_tb.sv
`timescale 1ns/1ps
module lmu_top_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_valid;
  logic [63:0] out_data;

  int n_tests;
  int n_fail;
  int cyc;
  bit mon_on;
  logic [63:0] last_data;
  logic [31:0] lfsr;

  logic [63:0] exp_q[$];
  int          due_q[$];
  logic [1:0]  op_q[$];

  logic [15:0] corner [12];

  lmu_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  // Arithmetic model of the four operations (R1 lane layout and opcodes).
  function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    longint ps[4];
    longint pu[4];
    longint s;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      ps[i] = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
      pu[i] = longint'({48'd0, a[16*i +: 16]}) * longint'({48'd0, b[16*i +: 16]});
    end
    for (int i = 0; i < 4; i++) begin
      case (op)
        2'b00: r[16*i +: 16] = ps[i][15:0];
        2'b01: r[16*i +: 16] = ps[i][31:16];
        2'b10: r[16*i +: 16] = pu[i][31:16];
        default: ;
      endcase
    end
    if (op == 2'b11) begin
      s = ps[0] + ps[1];
      r[31:0] = s[31:0];
      s = ps[2] + ps[3];
      r[63:32] = s[31:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    exp_q.push_back(model(op, a, b));
    due_q.push_back(cyc + 2);
    op_q.push_back(op);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_a     = ~in_a;
    in_op    = in_op + 2'd1;
    @(negedge clk);
  endtask

  task automatic issue_get(logic [1:0] op, logic [63:0] a, logic [63:0] b, output logic [63:0] r);
    issue(op, a, b);
    idle();
    r = out_data;
  endtask

  // Monitor: results due this cycle (R7), data per opcode, hold otherwise (R8).
  always @(negedge clk) begin
    if (mon_on) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        check(out_valid == 1'b1, "R7", {63'd0, out_valid}, 64'd1);
        check(out_data == exp_q[0], req_of(op_q[0]), out_data, exp_q[0]);
        last_data = out_data;
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(op_q.pop_front());
      end else begin
        check(out_valid == 1'b0, "R7", {63'd0, out_valid}, 64'd0);
        check(out_data == last_data, "R8", out_data, last_data);
      end
    end
  end

  // R5: a low-half and a high-half result together rebuild the full product.
  task automatic split_check(logic [63:0] a, logic [63:0] b);
    logic [63:0] lo, hs, hu;
    longint fs, fu;
    logic [31:0] e;
    issue_get(2'b00, a, b, lo);
    issue_get(2'b01, a, b, hs);
    issue_get(2'b10, a, b, hu);
    for (int i = 0; i < 4; i++) begin
      fs = longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16]));
      fu = longint'({48'd0, a[16*i +: 16]}) * longint'({48'd0, b[16*i +: 16]});
      e = fs[31:0];
      check({hs[16*i +: 16], lo[16*i +: 16]} == e, "R5",
            {32'd0, hs[16*i +: 16], lo[16*i +: 16]}, {32'd0, e});
      e = fu[31:0];
      check({hu[16*i +: 16], lo[16*i +: 16]} == e, "R5",
            {32'd0, hu[16*i +: 16], lo[16*i +: 16]}, {32'd0, e});
    end
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    wait (cyc == 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<100000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b, r;
    corner[0]  = 16'h0000; corner[1]  = 16'h0001; corner[2]  = 16'h0002;
    corner[3]  = 16'h7fff; corner[4]  = 16'h8000; corner[5]  = 16'h8001;
    corner[6]  = 16'hffff; corner[7]  = 16'hfffe; corner[8]  = 16'h00ff;
    corner[9]  = 16'hff00; corner[10] = 16'h1234; corner[11] = 16'hc3a5;
    mon_on    = 1'b0;
    last_data = '0;
    lfsr      = 32'h1badf00d;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_op     = 2'b00;
    in_a      = '0;
    in_b      = '0;

    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is asserted
    check(out_valid == 1'b0 && out_data == 64'd0, "R9", out_data, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: still cleared after release, before any operation
    check(out_valid == 1'b0 && out_data == 64'd0, "R9", out_data, 64'd0);
    mon_on = 1'b1;

    // R6 boundary: every lane -32768 wraps to 0x80000000 in each half
    issue_get(2'b11, {4{16'h8000}}, {4{16'h8000}}, r);
    check(r == 64'h80000000_80000000, "R6", r, 64'h80000000_80000000);
    // R3/R4: signedness of the high half at the extremes
    issue_get(2'b01, {4{16'hffff}}, {4{16'hffff}}, r);
    check(r == 64'h0, "R3", r, 64'h0);
    issue_get(2'b10, {4{16'hffff}}, {4{16'hffff}}, r);
    check(r == {4{16'hfffe}}, "R4", r, {4{16'hfffe}});
    // R2/R1: distinct lanes land in their own positions
    issue_get(2'b00, 64'h0004_0003_0002_0001, 64'h0005_0005_0005_0005, r);
    check(r == 64'h0014_000f_000a_0005, "R1", r, 64'h0014_000f_000a_0005);

    // R5 reconstruction on corner and mixed patterns
    split_check({16'h8000, 16'h7fff, 16'hffff, 16'h0001}, {16'h8000, 16'h8000, 16'h7fff, 16'hffff});
    split_check({16'hc3a5, 16'h1234, 16'hff00, 16'h00ff}, {16'h1234, 16'hc3a5, 16'h8001, 16'hfffe});

    // Back-to-back sweep over the corner set, every opcode (R2, R3, R4, R6, R7)
    for (int x = 0; x < 12; x++) begin
      for (int y = 0; y < 12; y++) begin
        for (int op = 0; op < 4; op++) begin
          for (int i = 0; i < 4; i++) begin
            a[16*i +: 16] = corner[(x + i) % 12];
            b[16*i +: 16] = corner[(y + 3*i) % 12];
          end
          issue(2'(op), a, b);
        end
      end
    end

    // Random operands with random idle gaps (R7, R8)
    for (int k = 0; k < 3000; k++) begin
      lfsr = next_rand(lfsr); a[31:0]  = lfsr;
      lfsr = next_rand(lfsr); a[63:32] = lfsr;
      lfsr = next_rand(lfsr); b[31:0]  = lfsr;
      lfsr = next_rand(lfsr); b[63:32] = lfsr;
      lfsr = next_rand(lfsr);
      issue(lfsr[1:0], a, b);
      if (lfsr[7]) idle();
      if (lfsr[8] && lfsr[9]) idle();
    end

    repeat (4) idle();
    check(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule